// File: doc/BRIEF.md
# SPI Transmit Queue with Fill, Completion and Underflow Flags

This block buffers outgoing SPI frames between a host-facing push register and the serializer's shift register. A host or DMA engine writes 32-bit words into the queue. The serializer side raises a ready signal whenever it can take a word, and the queue hands over the oldest entry one cycle later. This continues every cycle while entries remain. An entry counter reports how many words are waiting.

Three status flags travel with the queue. The fill flag says there is room for another word, and it is routed to either an interrupt line or a DMA request line. The completion flag records the end of a frame transfer. The underflow flag records that, in slave mode, an external master started a transfer while nothing was queued. Software clears any flag by writing a 1 to its bit. A separate flush strobe empties the queue at once.

Top module: `spi_txq`

## Requirements
- R1: After a synchronous reset, `count` is 0, `fill_flag` is 1, `done_flag` and `unf_flag` are 0, and `sh_load` is 0.
- R2: A push while `count` < DEPTH stores `push_data` at the tail, and `count` rises by one on the next cycle.
- R3: A push while `count` == DEPTH is dropped. The count stays at DEPTH, the stored words are unchanged, and no flag changes because of it.
- R4: When `sh_ready` is high and `count` > 0, the next cycle shows `sh_load` = 1 with the oldest word on `sh_data`, and `count` falls by one. Words leave in push order, one per cycle, while `sh_ready` stays high. No load occurs when the queue is empty.
- R5: A push and a pull in the same cycle both take effect, and `count` is unchanged.
- R6: At each clock edge where `count` < DEPTH, `fill_flag` becomes 1. At an edge where `count` == DEPTH and `push_done` is high, `fill_flag` becomes 0. Otherwise it holds.
- R7: `stat_w1c` bit 0 set to 1 clears `fill_flag` on the next cycle. This takes priority over R6.
- R8: `fill_irq` equals `fill_flag` while `fill_dma_sel` is 0, and `fill_dma` equals `fill_flag` while `fill_dma_sel` is 1. The unselected output is 0.
- R9: `xfer_done` sets `done_flag` on the next cycle. The flag holds until `stat_w1c` bit 1 is written with 1. A set and a clear in the same cycle leave it set.
- R10: `unf_flag` sets on the next cycle when `slave_mode` and `ext_start` are both high while `count` is 0. It does not set in master mode or when the queue is non-empty. `stat_w1c` bit 2 clears it, and a set in the same cycle wins.
- R11: `flush_req` makes `count` 0 on the next cycle. Any push or pull in that same cycle is discarded, so no load follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Host write strobe to the push register |
| push_data | input | DATA_W | Word to enqueue |
| push_done | input | 1 | DMA side reports its push write complete |
| stat_w1c | input | 3 | Write-one-to-clear: bit 0 fill, bit 1 done, bit 2 underflow |
| flush_req | input | 1 | Empty the queue |
| fill_dma_sel | input | 1 | Route fill flag to DMA (1) or interrupt (0) |
| sh_ready | input | 1 | Shift register can accept a word |
| xfer_done | input | 1 | End of a frame transfer |
| slave_mode | input | 1 | Block operates as SPI slave |
| ext_start | input | 1 | External master starts a transfer |
| sh_load | output | 1 | Word presented on sh_data this cycle |
| sh_data | output | DATA_W | Word handed to the shift register |
| count | output | $clog2(DEPTH+1) | Number of queued words |
| fill_flag | output | 1 | Room available |
| fill_irq | output | 1 | Fill interrupt request |
| fill_dma | output | 1 | Fill DMA request |
| done_flag | output | 1 | Sticky transfer-complete flag |
| unf_flag | output | 1 | Sticky slave underflow flag |

## Verification
The bench fills the queue and pushes once more. A design that let the extra word in would wrap its write pointer over the oldest word, and the drain would return the wrong data. The bench holds push and pull together at several fill levels. A design that gave one of them priority would make `count` drift. The bench also collides set and clear writes on the sticky flags, where the wrong priority loses an event. It raises a flush together with a push and a ready, and a design that let either through would leave a stray word or emit a load. Finally, it clears the fill flag while the queue is full and while it is not, which catches a fill flag that re-sets too early or never drops.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  // Bit positions inside the write-one-to-clear status strobe
  localparam int W1C_FILL = 0;
  localparam int W1C_DONE = 1;
  localparam int W1C_UNF  = 2;
  localparam int W1C_W    = 3;

  // Sticky event flags handled by the generic loop in the flag unit
  localparam int N_STICKY = 2;
  localparam int STK_DONE = 0;
  localparam int STK_UNF  = 1;
endpackage

// File: rtl/spi_txq_ptrs.sv
module spi_txq_ptrs #(
  parameter  int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic             flush_req,
  input  logic             sh_ready,
  output logic             wr_en,
  output logic             rd_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full  = (count == CNT_MAX);
    empty = (count == '0);
    wr_en = push_valid && !full && !flush_req;
    rd_en = sh_ready && !empty && !flush_req;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_req) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_txq_store.sv
module spi_txq_store #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port array with registered read, no reset on data
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/spi_txq_flags.sv
module spi_txq_flags
  import spi_txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             full,
  input  logic             empty,
  input  logic             push_done,
  input  logic [W1C_W-1:0] stat_w1c,
  input  logic             xfer_done,
  input  logic             slave_mode,
  input  logic             ext_start,
  input  logic             fill_dma_sel,
  output logic             fill_flag,
  output logic             fill_irq,
  output logic             fill_dma,
  output logic             done_flag,
  output logic             unf_flag
);
  logic [N_STICKY-1:0] evt;
  logic [N_STICKY-1:0] clr;
  logic [N_STICKY-1:0] sticky;

  always_comb begin
    evt[STK_DONE] = xfer_done;
    evt[STK_UNF]  = slave_mode && ext_start && empty;
    clr[STK_DONE] = stat_w1c[W1C_DONE];
    clr[STK_UNF]  = stat_w1c[W1C_UNF];
  end

  // Event flags: set wins over a clear in the same cycle
  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    logic q;
    always_ff @(posedge clk) begin
      if (rst)         q <= 1'b0;
      else if (evt[i]) q <= 1'b1;
      else if (clr[i]) q <= 1'b0;
    end
    assign sticky[i] = q;
  end

  // Fill flag: software clear first, then room, then full-and-written
  always_ff @(posedge clk) begin
    if (rst)                     fill_flag <= 1'b1;
    else if (stat_w1c[W1C_FILL]) fill_flag <= 1'b0;
    else if (!full)              fill_flag <= 1'b1;
    else if (push_done)          fill_flag <= 1'b0;
  end

  assign fill_irq  = fill_flag && !fill_dma_sel;
  assign fill_dma  = fill_flag &&  fill_dma_sel;
  assign done_flag = sticky[STK_DONE];
  assign unf_flag  = sticky[STK_UNF];
endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_done,
  input  logic [W1C_W-1:0]  stat_w1c,
  input  logic              flush_req,
  input  logic              fill_dma_sel,
  input  logic              sh_ready,
  input  logic              xfer_done,
  input  logic              slave_mode,
  input  logic              ext_start,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_data,
  output logic [CNT_W-1:0]  count,
  output logic              fill_flag,
  output logic              fill_irq,
  output logic              fill_dma,
  output logic              done_flag,
  output logic              unf_flag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             wr_en, rd_en, full, empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  spi_txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_valid(push_valid), .flush_req(flush_req),
    .sh_ready(sh_ready), .wr_en(wr_en), .rd_en(rd_en), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .count(count), .full(full), .empty(empty)
  );

  spi_txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr), .wr_data(push_data),
    .rd_en(rd_en), .rd_addr(rd_ptr), .rd_data(sh_data)
  );

  spi_txq_flags u_flags (
    .clk(clk), .rst(rst), .full(full), .empty(empty), .push_done(push_done),
    .stat_w1c(stat_w1c), .xfer_done(xfer_done), .slave_mode(slave_mode),
    .ext_start(ext_start), .fill_dma_sel(fill_dma_sel), .fill_flag(fill_flag),
    .fill_irq(fill_irq), .fill_dma(fill_dma), .done_flag(done_flag),
    .unf_flag(unf_flag)
  );

  // Load strobe aligned with the registered read data
  always_ff @(posedge clk) begin
    if (rst) sh_load <= 1'b0;
    else     sh_load <= rd_en;
  end
endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_valid,
  input logic             push_done,
  input logic [2:0]       stat_w1c,
  input logic             flush_req,
  input logic             sh_ready,
  input logic             xfer_done,
  input logic             slave_mode,
  input logic             ext_start,
  input logic             sh_load,
  input logic [CNT_W-1:0] count,
  input logic             fill_flag,
  input logic             fill_irq,
  input logic             fill_dma,
  input logic             done_flag,
  input logic             unf_flag
);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && push_valid && !sh_ready && !flush_req) |=> (count == CMAX));

  a_r3_bound: assert property (@(posedge clk) disable iff (rst) count <= CMAX);

  a_r4_pull_dec: assert property (@(posedge clk) disable iff (rst)
    (sh_ready && count != 0 && !push_valid && !flush_req) |=>
      (sh_load && count == $past(count) - 1'b1));

  a_r4_no_load_empty: assert property (@(posedge clk) disable iff (rst)
    (count == 0 || !sh_ready) |=> !sh_load);

  a_r5_balanced: assert property (@(posedge clk) disable iff (rst)
    (sh_ready && push_valid && count != 0 && count != CMAX && !flush_req) |=> $stable(count));

  a_r6_room_sets: assert property (@(posedge clk) disable iff (rst)
    (count != CMAX && !stat_w1c[0]) |=> fill_flag);

  a_r6_full_written: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && push_done) |=> !fill_flag);

  a_r7_w1c_fill: assert property (@(posedge clk) disable iff (rst)
    stat_w1c[0] |=> !fill_flag);

  a_r8_one_route: assert property (@(posedge clk) disable iff (rst)
    !(fill_irq && fill_dma));

  a_r9_done_set: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> done_flag);

  a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
    (!xfer_done && !stat_w1c[1]) |=> $stable(done_flag));

  a_r10_unf_set: assert property (@(posedge clk) disable iff (rst)
    (slave_mode && ext_start && count == 0) |=> unf_flag);

  a_r10_unf_quiet: assert property (@(posedge clk) disable iff (rst)
    (!unf_flag && !(slave_mode && ext_start && count == 0)) |=> !unf_flag);

  a_r11_flush: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> (count == 0 && !sh_load));
endmodule

bind spi_txq spi_txq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push_valid(push_valid), .push_done(push_done),
  .stat_w1c(stat_w1c), .flush_req(flush_req), .sh_ready(sh_ready),
  .xfer_done(xfer_done), .slave_mode(slave_mode), .ext_start(ext_start),
  .sh_load(sh_load), .count(count), .fill_flag(fill_flag), .fill_irq(fill_irq),
  .fill_dma(fill_dma), .done_flag(done_flag), .unf_flag(unf_flag)
);

// File: tb/spi_txq_test.sv
module spi_txq_test;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          push_valid = 0, push_done = 0, flush_req = 0, fill_dma_sel = 0;
  logic [DW-1:0] push_data = '0;
  logic [2:0]    stat_w1c = '0;
  logic          sh_ready = 0, xfer_done = 0, slave_mode = 0, ext_start = 0;
  logic          sh_load, fill_flag, fill_irq, fill_dma, done_flag, unf_flag;
  logic [DW-1:0] sh_data;
  logic [CW-1:0] count;

  spi_txq #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .push_done(push_done), .stat_w1c(stat_w1c), .flush_req(flush_req),
    .fill_dma_sel(fill_dma_sel), .sh_ready(sh_ready), .xfer_done(xfer_done),
    .slave_mode(slave_mode), .ext_start(ext_start), .sh_load(sh_load),
    .sh_data(sh_data), .count(count), .fill_flag(fill_flag), .fill_irq(fill_irq),
    .fill_dma(fill_dma), .done_flag(done_flag), .unf_flag(unf_flag)
  );

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  logic [DW-1:0] mq[$];
  bit            m_fill = 1, m_done = 0, m_unf = 0, m_load = 0;
  bit            m_full, m_empty, m_pull, m_push;
  logic [DW-1:0] m_data;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_fill = 1; m_done = 0; m_unf = 0; m_load = 0;
    end else begin
      m_full  = (mq.size() == DEPTH);
      m_empty = (mq.size() == 0);
      if (stat_w1c[0])    m_fill = 0;
      else if (!m_full)   m_fill = 1;
      else if (push_done) m_fill = 0;
      if (xfer_done)        m_done = 1;
      else if (stat_w1c[1]) m_done = 0;
      if (slave_mode && ext_start && m_empty) m_unf = 1;
      else if (stat_w1c[2])                   m_unf = 0;
      if (flush_req) begin
        mq.delete();
        m_load = 0;
      end else begin
        m_pull = sh_ready && !m_empty;
        m_push = push_valid && !m_full;
        m_load = m_pull;
        if (m_pull) m_data = mq.pop_front();
        if (m_push) mq.push_back(push_data);
      end
    end
  end

  task automatic compare_all();
    chk("R2/R4 count", 64'(count), 64'(mq.size()));
    chk("R6/R7 fill_flag", 64'(fill_flag), 64'(m_fill));
    chk("R8 fill_irq", 64'(fill_irq), 64'(m_fill && !fill_dma_sel));
    chk("R8 fill_dma", 64'(fill_dma), 64'(m_fill && fill_dma_sel));
    chk("R9 done_flag", 64'(done_flag), 64'(m_done));
    chk("R10 unf_flag", 64'(unf_flag), 64'(m_unf));
    chk("R4 sh_load", 64'(sh_load), 64'(m_load));
    if (m_load) chk("R4 sh_data", 64'(sh_data), 64'(m_data));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (cmp_on) compare_all();
  endtask

  task automatic quiet();
    push_valid = 0; push_done = 0; flush_req = 0; stat_w1c = '0;
    sh_ready = 0; xfer_done = 0; ext_start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 64'(count), 0);
    chk("R1 fill_flag", 64'(fill_flag), 1);
    chk("R1 done_flag", 64'(done_flag), 0);
    chk("R1 unf_flag", 64'(unf_flag), 0);
    chk("R1 sh_load", 64'(sh_load), 0);
    rst = 0;
    cmp_on = 1;

    // R2 fill to the top
    for (int i = 0; i < DEPTH; i++) begin
      push_valid = 1; push_data = 32'hA000_0000 + i;
      tick();
    end
    chk("R2 count full", 64'(count), DEPTH);
    // R3 extra push dropped
    push_data = 32'hDEAD_BEEF;
    tick();
    chk("R3 count held", 64'(count), DEPTH);
    chk("R3 no error flag", 64'({done_flag, unf_flag}), 0);
    push_valid = 0; push_done = 1;
    tick();
    chk("R6 fill drops when full and written", 64'(fill_flag), 0);
    push_done = 0;
    tick();
    chk("R6 fill holds while full", 64'(fill_flag), 0);

    // R4 drain in order
    sh_ready = 1;
    tick();
    chk("R4 first word", 64'(sh_data), 32'hA000_0000);
    chk("R4 count dec", 64'(count), DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) begin
      tick();
      chk("R4 order", 64'(sh_data), 32'hA000_0000 + i);
    end
    chk("R3 last word not the dropped one", 64'(sh_data), 32'hA000_0003);
    tick();
    chk("R4 no load when empty", 64'(sh_load), 0);
    chk("R6 fill back up", 64'(fill_flag), 1);

    // R5 simultaneous push and pull
    sh_ready = 0; push_valid = 1; push_data = 32'hB000_0000;
    tick();
    for (int i = 1; i < 4; i++) begin
      sh_ready = 1; push_data = 32'hB000_0000 + i;
      tick();
      chk("R5 count stable", 64'(count), 1);
    end
    push_valid = 0;
    tick();
    chk("R5 drained last", 64'(sh_data), 32'hB000_0003);

    // R7 write-one-to-clear on fill flag
    quiet(); stat_w1c = 3'b001;
    tick();
    chk("R7 fill cleared", 64'(fill_flag), 0);
    stat_w1c = 3'b000;
    tick();
    chk("R6 fill re-set with room", 64'(fill_flag), 1);

    // R8 routing
    fill_dma_sel = 1; #1;
    chk("R8 dma route", 64'({fill_irq, fill_dma}), 2'b01);
    fill_dma_sel = 0; #1;
    chk("R8 irq route", 64'({fill_irq, fill_dma}), 2'b10);

    // R9 transfer-complete flag
    xfer_done = 1; tick();
    chk("R9 set", 64'(done_flag), 1);
    xfer_done = 0; tick();
    chk("R9 sticky", 64'(done_flag), 1);
    stat_w1c = 3'b010; tick();
    chk("R9 cleared", 64'(done_flag), 0);
    xfer_done = 1; tick();
    chk("R9 set beats clear", 64'(done_flag), 1);
    quiet(); stat_w1c = 3'b010; tick();
    stat_w1c = 3'b000;

    // R10 underflow in slave mode only
    ext_start = 1; tick();
    chk("R10 master mode quiet", 64'(unf_flag), 0);
    ext_start = 0; slave_mode = 1; push_valid = 1; push_data = 32'hC1; tick();
    push_valid = 0; ext_start = 1; tick();
    chk("R10 non-empty quiet", 64'(unf_flag), 0);
    ext_start = 0; sh_ready = 1; tick();
    sh_ready = 0; ext_start = 1; tick();
    chk("R10 set on empty", 64'(unf_flag), 1);
    ext_start = 0; stat_w1c = 3'b100; tick();
    chk("R10 cleared", 64'(unf_flag), 0);
    quiet(); slave_mode = 0;

    // R11 flush with a colliding push and pull
    push_valid = 1;
    for (int i = 0; i < 3; i++) begin push_data = 32'hD0 + i; tick(); end
    flush_req = 1; sh_ready = 1; push_data = 32'hDF;
    tick();
    chk("R11 count zero", 64'(count), 0);
    chk("R11 no load", 64'(sh_load), 0);
    quiet(); push_valid = 1; push_data = 32'hE0; tick();
    push_valid = 0; sh_ready = 1; tick();
    chk("R11 fresh data after flush", 64'(sh_data), 32'hE0);
    quiet();

    // Mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      push_valid   = ($urandom_range(0, 99) < 55);
      push_data    = $urandom;
      push_done    = ($urandom_range(0, 99) < 20);
      sh_ready     = ($urandom_range(0, 99) < 45);
      flush_req    = ($urandom_range(0, 99) < 3);
      stat_w1c     = ($urandom_range(0, 99) < 15) ? 3'($urandom_range(1, 7)) : 3'b000;
      xfer_done    = ($urandom_range(0, 99) < 10);
      slave_mode   = ($urandom_range(0, 99) < 50);
      ext_start    = ($urandom_range(0, 99) < 10);
      fill_dma_sel = ($urandom_range(0, 99) < 50);
      tick();
    end
    quiet();
    tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule